// File: doc/BRIEF.md
# Expansion Port 4:2:2 Video Receiver

This block takes in a component video stream from an external video device. In narrow mode the stream arrives as one byte per qualified clock on the primary bus. In wide mode luma arrives on the primary bus while chroma arrives at the same time on a second bus. A qualifier input marks which clocks carry a sample, so the upstream device can send a sparse stream or gate its clock. The block rebuilds pixel pairs (two luma samples plus one Cb and one Cr) and writes them into a small internal FIFO. Each pair carries a line-start flag, a field-start flag and the current field identifier.

Line and field timing come from one of two sources, chosen by a control bit. The first is the horizontal and vertical reference inputs, each with a selectable active edge. The second is timing codes embedded in the byte stream, which are removed from the video. A ready output tells the sender to hold off before the FIFO fills. A receive-enable request takes effect only at a field boundary, so a field is always received whole or not at all.

Top module: `xport_rx`

## Requirements
- R1: In narrow mode (`cfg_wide`=0), each qualified video byte on `in_luma` is taken in the order Cb, Y0, Cr, Y1. After the fourth byte, one pair {Y0,Y1,Cb,Cr} is queued.
- R2: In wide mode (`cfg_wide`=1), each qualified word supplies Y from `in_luma` and chroma from `in_chroma`. The first word gives Y0 and Cb, the second gives Y1 and Cr, and then one pair is queued.
- R3: A clock with `in_valid`=0 has no effect: its bus, reference and code contents are ignored.
- R4: In reference mode (`cfg_code_en`=0), video bytes are those with `in_href` at its active level. The active level is 1 when `cfg_href_rise`=1 and 0 otherwise. The first such byte after an inactive one is a line start: the component phase restarts so that byte is Cb, and the pair it begins has `out_sol`=1.
- R5: In reference mode, a qualified byte on which `in_vref` reaches its active level (1 when `cfg_vref_rise`=1) from the other level is a field start. That byte is not video. `out_fid` becomes 1 if `in_href` is at its active level on that byte, otherwise 0. The next line-start pair has `out_sof`=1.
- R6: In code mode (`cfg_code_en`=1), a code is the byte sequence FF, 00, 00, XY on `in_luma`, where XY bit 4 = 1 marks line end, bit 5 is vertical blanking and bit 6 is the field bit. Code bytes never appear as video. Video is taken only between a line-begin code with bit 5 = 0 and the next line-end code, and the first byte after the line-begin code is Cb with `out_sol`=1. `in_href` and `in_vref` are ignored.
- R7: In code mode, the first line-begin code with bit 5 = 0 after reset or after any code with bit 5 = 1 is a field start. `out_fid` takes XY bit 6, and that line's first pair has `out_sof`=1. Later line-begin codes in the same field set neither.
- R8: Pairs are held in a FIFO of `DEPTH` (16) entries and leave in order while `out_pop`=1 and `out_valid`=1. `in_ready` is 0 exactly when 12 or more entries are held. Pairs arriving while the FIFO is full are dropped, and the held ones are not changed.
- R9: `rx_on` takes the value of `rx_dir_req` only at a field start (R5 or R7). While `rx_on`=0 no pair is queued.
- R10: After reset, `out_valid`=0, `in_ready`=1 and `rx_on`=0.
- R11: A line start that arrives before a pair is complete discards the partial pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1: separate luma and chroma buses; 0: byte-serial |
| cfg_code_en | input | 1 | 1: timing from embedded codes; 0: from reference inputs |
| cfg_href_rise | input | 1 | Active level/edge of the horizontal reference (1 = rising) |
| cfg_vref_rise | input | 1 | Active edge of the vertical reference (1 = rising) |
| rx_dir_req | input | 1 | Requested receive enable, applied at the next field start |
| in_valid | input | 1 | Sample qualifier |
| in_luma | input | 8 | Primary bus: serial bytes or luma |
| in_chroma | input | 8 | Chroma bus in wide mode |
| in_href | input | 1 | Horizontal reference |
| in_vref | input | 1 | Vertical reference |
| in_ready | output | 1 | Sender may continue |
| rx_on | output | 1 | Receive enable in effect |
| out_pop | input | 1 | Consumer takes the head pair |
| out_valid | output | 1 | A pair is available |
| out_y0 | output | 8 | First luma of the pair |
| out_y1 | output | 8 | Second luma of the pair |
| out_cb | output | 8 | Blue-difference chroma |
| out_cr | output | 8 | Red-difference chroma |
| out_sol | output | 1 | Pair starts a line |
| out_sof | output | 1 | Pair starts a field |
| out_fid | output | 1 | Field identifier |

## Verification
A phase counter that is off by one shows up at the ports in the first pair after a line start: components land in the wrong fields one clock after the fourth qualified byte. A stale line-begin or blanking flag shows up as a wrong `out_sol` or `out_sof` on the first pair of the following line. A code detector stuck in a preamble state either leaks FF or 00 bytes into the pairs or swallows video, and the queued pairs then disagree with the scoreboard. A FIFO occupancy error appears as `in_ready` falling at the wrong pair count during the held-pop phase, or as missing or extra pairs when the FIFO drains.

// File: rtl/xrx_pkg.sv
package xrx_pkg;

    typedef struct packed {
        logic [7:0] y0;
        logic [7:0] y1;
        logic [7:0] cb;
        logic [7:0] cr;
        logic       sol;
        logic       sof;
        logic       fid;
    } xrx_pair_t;

    typedef enum logic [1:0] {
        CD_IDLE = 2'd0,
        CD_HI   = 2'd1,
        CD_Z1   = 2'd2,
        CD_Z2   = 2'd3
    } xrx_cd_state_t;

    localparam logic [7:0] XRX_MARK_HI = 8'hFF;
    localparam logic [7:0] XRX_MARK_LO = 8'h00;

    function automatic logic xrx_is_end(input logic [7:0] xy);
        return xy[4];
    endfunction

    function automatic logic xrx_vblank(input logic [7:0] xy);
        return xy[5];
    endfunction

    function automatic logic xrx_field(input logic [7:0] xy);
        return xy[6];
    endfunction

endpackage

// File: rtl/xrx_code_det.sv
module xrx_code_det
    import xrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [7:0] data,
    output logic       consumed,
    output logic       hit
);

    xrx_cd_state_t state_q, state_d;

    always_comb begin
        state_d  = state_q;
        consumed = 1'b0;
        hit      = 1'b0;
        if (en) begin
            unique case (state_q)
                CD_IDLE: begin
                    if (data == XRX_MARK_HI) begin
                        consumed = 1'b1;
                        state_d  = CD_HI;
                    end
                end
                CD_HI: begin
                    consumed = (data == XRX_MARK_LO) || (data == XRX_MARK_HI);
                    state_d  = (data == XRX_MARK_LO) ? CD_Z1 :
                               (data == XRX_MARK_HI) ? CD_HI : CD_IDLE;
                end
                CD_Z1: begin
                    consumed = (data == XRX_MARK_LO) || (data == XRX_MARK_HI);
                    state_d  = (data == XRX_MARK_LO) ? CD_Z2 :
                               (data == XRX_MARK_HI) ? CD_HI : CD_IDLE;
                end
                CD_Z2: begin
                    consumed = 1'b1;
                    hit      = data[7];
                    state_d  = CD_IDLE;
                end
                default: state_d = CD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CD_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/xrx_assembler.sv
module xrx_assembler
    import xrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wide,
    input  logic       take,
    input  logic       line_start,
    input  logic [7:0] luma,
    input  logic [7:0] chroma,
    input  logic       sof_in,
    input  logic       fid_in,
    output logic       push,
    output xrx_pair_t  pair
);

    logic [1:0] phase_q, ph, ph_next;
    xrx_pair_t  acc_q;
    logic       last;

    always_comb begin
        ph      = line_start ? 2'd0 : phase_q;
        last    = wide ? (ph == 2'd1) : (ph == 2'd3);
        ph_next = wide ? {1'b0, ~ph[0]} : ph + 2'd1;
        push    = take && last;
        pair    = acc_q;
        pair.y1 = luma;
        if (wide) pair.cr = chroma;
        pair.fid = fid_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 2'd0;
            acc_q   <= '0;
        end else if (take) begin
            phase_q <= ph_next;
            if (wide) begin
                if (ph == 2'd0) begin
                    acc_q.y0 <= luma;
                    acc_q.cb <= chroma;
                end else begin
                    acc_q.sol <= 1'b0;
                    acc_q.sof <= 1'b0;
                end
            end else begin
                unique case (ph)
                    2'd0: acc_q.cb <= luma;
                    2'd1: acc_q.y0 <= luma;
                    2'd2: acc_q.cr <= luma;
                    default: begin
                        acc_q.sol <= 1'b0;
                        acc_q.sof <= 1'b0;
                    end
                endcase
            end
            if (line_start) begin
                acc_q.sol <= 1'b1;
                acc_q.sof <= sof_in;
            end
        end
    end

endmodule

// File: rtl/xrx_fifo.sv
module xrx_fifo #(
    parameter int W     = 35,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [W-1:0]                 wr_data,
    input  logic                         rd_en,
    output logic [W-1:0]                 rd_data,
    output logic                         rd_valid,
    output logic [$clog2(DEPTH+1)-1:0]   level
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;
    logic          do_wr, do_rd;

    always_comb begin
        do_wr    = wr_en && (cnt_q != CW'(DEPTH));
        do_rd    = rd_en && (cnt_q != '0);
        rd_valid = (cnt_q != '0);
        rd_data  = mem[rptr_q];
        level    = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_wr) wptr_q <= (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
            if (do_rd) rptr_q <= (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
            if (do_wr && !do_rd)      cnt_q <= cnt_q + 1'b1;
            else if (do_rd && !do_wr) cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/xport_rx.sv
module xport_rx
    import xrx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int THRESH = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wide,
    input  logic       cfg_code_en,
    input  logic       cfg_href_rise,
    input  logic       cfg_vref_rise,
    input  logic       rx_dir_req,
    input  logic       in_valid,
    input  logic [7:0] in_luma,
    input  logic [7:0] in_chroma,
    input  logic       in_href,
    input  logic       in_vref,
    output logic       in_ready,
    output logic       rx_on,
    input  logic       out_pop,
    output logic       out_valid,
    output logic [7:0] out_y0,
    output logic [7:0] out_y1,
    output logic [7:0] out_cb,
    output logic [7:0] out_cr,
    output logic       out_sol,
    output logic       out_sof,
    output logic       out_fid
);

    localparam int CW = $clog2(DEPTH+1);
    localparam int PW = $bits(xrx_pair_t);

    logic href_q, vref_q, rx_on_q, sof_pend, fid_q;
    logic code_act, lstart_pend, vblank_q;
    logic code_consumed, code_hit;
    logic v_edge, h_byte, ref_take, ref_ls;
    logic sav_open, field_code, code_take, code_ls;
    logic field_evt, take, line_start, push;
    xrx_pair_t       pair, head;
    logic [PW-1:0]   head_bits;
    logic [CW-1:0]   fifo_count;

    xrx_code_det u_det (
        .clk      (clk),
        .rst      (rst),
        .en       (in_valid && cfg_code_en),
        .data     (in_luma),
        .consumed (code_consumed),
        .hit      (code_hit)
    );

    always_comb begin
        v_edge     = in_valid && !cfg_code_en &&
                     (in_vref == cfg_vref_rise) && (vref_q != cfg_vref_rise);
        h_byte     = in_valid && !cfg_code_en && !v_edge;
        ref_take   = h_byte && (in_href == cfg_href_rise);
        ref_ls     = ref_take && (href_q != cfg_href_rise);
        sav_open   = code_hit && !xrx_is_end(in_luma) && !xrx_vblank(in_luma);
        field_code = sav_open && vblank_q;
        code_take  = in_valid && cfg_code_en && !code_consumed && code_act;
        code_ls    = code_take && lstart_pend;
        field_evt  = v_edge || field_code;
        take       = rx_on_q && (cfg_code_en ? code_take : ref_take);
        line_start = rx_on_q && (cfg_code_en ? code_ls : ref_ls);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            href_q      <= 1'b0;
            vref_q      <= 1'b0;
            rx_on_q     <= 1'b0;
            sof_pend    <= 1'b0;
            fid_q       <= 1'b0;
            code_act    <= 1'b0;
            lstart_pend <= 1'b0;
            vblank_q    <= 1'b1;
        end else begin
            if (in_valid && !cfg_code_en) vref_q <= in_vref;
            if (h_byte) href_q <= in_href;

            if (code_hit) begin
                if (xrx_is_end(in_luma)) begin
                    code_act <= 1'b0;
                end else begin
                    code_act    <= !xrx_vblank(in_luma);
                    lstart_pend <= !xrx_vblank(in_luma);
                end
                if (xrx_vblank(in_luma)) vblank_q <= 1'b1;
                else if (sav_open)       vblank_q <= 1'b0;
            end else if (code_ls) begin
                lstart_pend <= 1'b0;
            end

            if (field_evt) begin
                rx_on_q  <= rx_dir_req;
                sof_pend <= 1'b1;
                fid_q    <= cfg_code_en ? xrx_field(in_luma)
                                        : (in_href == cfg_href_rise);
            end else if (take && line_start) begin
                sof_pend <= 1'b0;
            end
        end
    end

    xrx_assembler u_asm (
        .clk        (clk),
        .rst        (rst),
        .wide       (cfg_wide),
        .take       (take),
        .line_start (line_start),
        .luma       (in_luma),
        .chroma     (in_chroma),
        .sof_in     (sof_pend),
        .fid_in     (fid_q),
        .push       (push),
        .pair       (pair)
    );

    xrx_fifo #(.W(PW), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (push),
        .wr_data  (pair),
        .rd_en    (out_pop),
        .rd_data  (head_bits),
        .rd_valid (out_valid),
        .level    (fifo_count)
    );

    always_comb begin
        head     = xrx_pair_t'(head_bits);
        out_y0   = head.y0;
        out_y1   = head.y1;
        out_cb   = head.cb;
        out_cr   = head.cr;
        out_sol  = head.sol;
        out_sof  = head.sof;
        out_fid  = head.fid;
        in_ready = (fifo_count < CW'(THRESH));
        rx_on    = rx_on_q;
    end

endmodule

// File: rtl/xrx_checker.sv
module xrx_checker #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic                       code_consumed,
    input logic                       push,
    input logic                       pair_sol,
    input logic                       pair_sof,
    input logic                       rx_on,
    input logic                       field_evt,
    input logic                       out_valid,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count
);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= ($clog2(DEPTH+1))'(DEPTH));

    assert_valid_from_write_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(push));

    assert_idle_clock_R3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !push);

    assert_code_not_video_R6: assert property (@(posedge clk) disable iff (rst)
        code_consumed |-> !push);

    assert_sof_with_sol_R5: assert property (@(posedge clk) disable iff (rst)
        (push && pair_sof) |-> pair_sol);

    assert_dir_at_field_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_on != $past(rx_on)) |-> $past(field_evt));

endmodule

bind xport_rx xrx_checker #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .code_consumed (code_consumed),
    .push          (push),
    .pair_sol      (pair.sol),
    .pair_sof      (pair.sof),
    .rx_on         (rx_on_q),
    .field_evt     (field_evt),
    .out_valid     (out_valid),
    .fifo_count    (fifo_count)
);

// File: tb/tb_xport_rx.sv
`timescale 1ns/1ps
module tb_xport_rx;
    import xrx_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wide = 1'b0, cfg_code_en = 1'b0, cfg_href_rise = 1'b1, cfg_vref_rise = 1'b1;
    logic rx_dir_req = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_luma = 8'h00, in_chroma = 8'h00;
    logic in_href = 1'b0, in_vref = 1'b0;
    logic in_ready, rx_on, out_pop, out_valid;
    logic [7:0] out_y0, out_y1, out_cb, out_cr;
    logic out_sol, out_sof, out_fid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    xrx_pair_t exp_q[$];
    string     tag_q[$];

    always #10 clk = ~clk;

    initial out_pop = 1'b1;

    xport_rx dut (
        .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_code_en(cfg_code_en),
        .cfg_href_rise(cfg_href_rise), .cfg_vref_rise(cfg_vref_rise),
        .rx_dir_req(rx_dir_req), .in_valid(in_valid), .in_luma(in_luma),
        .in_chroma(in_chroma), .in_href(in_href), .in_vref(in_vref),
        .in_ready(in_ready), .rx_on(rx_on), .out_pop(out_pop),
        .out_valid(out_valid), .out_y0(out_y0), .out_y1(out_y1),
        .out_cb(out_cb), .out_cr(out_cr), .out_sol(out_sol),
        .out_sof(out_sof), .out_fid(out_fid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic expect_pair(input logic [7:0] y0, y1, cb, cr,
                               input logic sol, sof, fid, input string tag);
        xrx_pair_t p;
        p.y0 = y0; p.y1 = y1; p.cb = cb; p.cr = cr;
        p.sol = sol; p.sof = sof; p.fid = fid;
        exp_q.push_back(p);
        tag_q.push_back(tag);
    endtask

    // monitor: compares each popped pair against the scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid && out_pop) begin
            xrx_pair_t got;
            got = {out_y0, out_y1, out_cb, out_cr, out_sol, out_sof, out_fid};
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected pair R9", int'(got[31:0]), 0);
            end else begin
                xrx_pair_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(got == e, t, int'(got[31:0]), int'(e[31:0]));
                if (got[2:0] != e[2:0])
                    $display("  flags sol/sof/fid got %b expected %b", got[2:0], e[2:0]);
            end
        end
    end

    task automatic sb(input logic [7:0] l, input logic [7:0] c, input logic h, input logic v);
        @(posedge clk); #2;
        in_valid = 1'b1; in_luma = l; in_chroma = c; in_href = h; in_vref = v;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #2;
            in_valid = 1'b0; in_luma = 8'hFF; in_chroma = 8'h00;
        end
    endtask

    task automatic code(input logic [7:0] xy);
        sb(8'hFF, 8'h00, 1'b1, 1'b0);
        sb(8'h00, 8'h00, 1'b0, 1'b1);
        sb(8'h00, 8'h00, 1'b1, 1'b1);
        sb(xy,    8'h00, 1'b0, 1'b0);
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(posedge clk);
        idle(2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
        chk(rx_on == 1'b0, "R10 rx_on", rx_on, 0);

        // field start, href inactive -> fid 0
        sb(8'h01, 8'h00, 1'b0, 1'b0);
        sb(8'h02, 8'h00, 1'b0, 1'b1);
        idle(1);
        @(negedge clk);
        chk(rx_on == 1'b1, "R9 rx_on after field start", rx_on, 1);

        // line 1 with a qualifier gap
        expect_pair(8'h20, 8'h40, 8'h10, 8'h30, 1, 1, 0, "R1 R4 R5 line1 pair0");
        expect_pair(8'h60, 8'h80, 8'h50, 8'h70, 0, 0, 0, "R1 R3 line1 pair1");
        sb(8'h10, 0, 1, 1); sb(8'h20, 0, 1, 1);
        @(posedge clk); #2; in_valid = 1'b0; in_luma = 8'h77; in_href = 1'b0;
        @(posedge clk); #2; in_luma = 8'h66; in_href = 1'b1;
        sb(8'h30, 0, 1, 1); sb(8'h40, 0, 1, 1);
        idle(2);
        sb(8'h50, 0, 1, 1); sb(8'h60, 0, 1, 1); sb(8'h70, 0, 1, 1); sb(8'h80, 0, 1, 1);
        sb(8'h99, 0, 0, 1);

        // line 2 ends with a partial pair, line 3 restarts the phase
        expect_pair(8'h21, 8'h41, 8'h11, 8'h31, 1, 0, 0, "R4 line2");
        expect_pair(8'h22, 8'h42, 8'h12, 8'h32, 1, 0, 0, "R11 line3 after partial");
        sb(8'h11, 0, 1, 1); sb(8'h21, 0, 1, 1); sb(8'h31, 0, 1, 1); sb(8'h41, 0, 1, 1);
        sb(8'h51, 0, 1, 1); sb(8'h61, 0, 1, 1);
        sb(8'h98, 0, 0, 1);
        sb(8'h12, 0, 1, 1); sb(8'h22, 0, 1, 1); sb(8'h32, 0, 1, 1); sb(8'h42, 0, 1, 1);
        sb(8'h97, 0, 0, 1);

        // field start with href active -> fid 1, edge byte not video
        sb(8'h96, 0, 0, 0);
        sb(8'h95, 0, 1, 1);
        sb(8'h94, 0, 0, 1);
        expect_pair(8'h23, 8'h43, 8'h13, 8'h33, 1, 1, 1, "R5 field2 fid");
        sb(8'h13, 0, 1, 1); sb(8'h23, 0, 1, 1); sb(8'h33, 0, 1, 1); sb(8'h43, 0, 1, 1);
        sb(8'h93, 0, 0, 1);

        // request off mid-field: current field still received
        rx_dir_req = 1'b0;
        expect_pair(8'h24, 8'h44, 8'h14, 8'h34, 1, 0, 1, "R9 request held until field");
        sb(8'h14, 0, 1, 1); sb(8'h24, 0, 1, 1); sb(8'h34, 0, 1, 1); sb(8'h44, 0, 1, 1);
        sb(8'h92, 0, 0, 1);
        drain();
        @(negedge clk);
        chk(rx_on == 1'b1, "R9 rx_on before boundary", rx_on, 1);
        sb(8'h91, 0, 0, 0);
        sb(8'h90, 0, 0, 1);
        idle(1);
        @(negedge clk);
        chk(rx_on == 1'b0, "R9 rx_on off at boundary", rx_on, 0);
        sb(8'h15, 0, 1, 1); sb(8'h25, 0, 1, 1); sb(8'h35, 0, 1, 1); sb(8'h45, 0, 1, 1);
        sb(8'h8F, 0, 0, 1);
        idle(3);
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 no pair while off", out_valid, 0);
        rx_dir_req = 1'b1;
        sb(8'h8E, 0, 0, 0);
        sb(8'h8D, 0, 0, 1);

        // wide mode
        cfg_wide = 1'b1;
        expect_pair(8'hA0, 8'hA1, 8'hC0, 8'hC1, 1, 1, 0, "R2 wide pair0");
        expect_pair(8'hA2, 8'hA3, 8'hC2, 8'hC3, 0, 0, 0, "R2 wide pair1");
        sb(8'hA0, 8'hC0, 1, 1); sb(8'hA1, 8'hC1, 1, 1);
        sb(8'hA2, 8'hC2, 1, 1); sb(8'hA3, 8'hC3, 1, 1);
        sb(8'h8C, 8'h8C, 0, 1);
        cfg_wide = 1'b0;

        // falling edges selected
        cfg_href_rise = 1'b0;
        cfg_vref_rise = 1'b0;
        sb(8'h8B, 0, 1, 1);
        sb(8'h8A, 0, 1, 0);
        expect_pair(8'h26, 8'h46, 8'h16, 8'h36, 1, 1, 0, "R4 R5 falling edges");
        sb(8'h16, 0, 0, 0); sb(8'h26, 0, 0, 0); sb(8'h36, 0, 0, 0); sb(8'h46, 0, 0, 0);
        sb(8'h89, 0, 1, 0);
        drain();

        // embedded codes
        cfg_code_en = 1'b1;
        code(8'hA0);
        code(8'hB0);
        code(8'hC0);
        expect_pair(8'h27, 8'h47, 8'h17, 8'h37, 1, 1, 1, "R6 R7 code field start");
        expect_pair(8'h67, 8'h87, 8'h57, 8'h77, 0, 0, 1, "R6 code line pair1");
        sb(8'h17, 0, 0, 1); sb(8'h27, 0, 1, 0); sb(8'h37, 0, 0, 0); sb(8'h47, 0, 1, 1);
        sb(8'h57, 0, 1, 1); sb(8'h67, 0, 0, 0); sb(8'h77, 0, 1, 0); sb(8'h87, 0, 0, 1);
        code(8'hD0);
        sb(8'h55, 0, 1, 1); sb(8'h66, 0, 0, 0);
        code(8'hC0);
        expect_pair(8'h28, 8'h48, 8'h18, 8'h38, 1, 0, 1, "R7 second line no sof");
        sb(8'h18, 0, 1, 0); sb(8'h28, 0, 0, 1); sb(8'h38, 0, 1, 1); sb(8'h48, 0, 0, 0);
        code(8'hD0);
        drain();
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 code bytes not queued", out_valid, 0);

        // back-pressure and overflow
        out_pop = 1'b0;
        code(8'hC0);
        for (int i = 1; i <= 18; i++) begin
            if (i <= 16)
                expect_pair(8'h40 + 8'(i), 8'hC0 + 8'(i), 8'h10 + 8'(i), 8'h80 + 8'(i),
                            (i == 1), 0, 1, "R8 fifo order");
            sb(8'h10 + 8'(i), 0, 0, 0);
            sb(8'h40 + 8'(i), 0, 0, 0);
            sb(8'h80 + 8'(i), 0, 0, 0);
            sb(8'hC0 + 8'(i), 0, 0, 0);
            if (i == 11 || i == 12) begin
                idle(1);
                @(negedge clk);
                chk(in_ready == (i == 11), "R8 ready threshold", in_ready, (i == 11));
            end
        end
        code(8'hD0);
        idle(1);
        @(negedge clk);
        chk(out_valid == 1'b1 && in_ready == 1'b0, "R8 full holds", {out_valid, in_ready}, 2);
        @(posedge clk); #2; out_pop = 1'b1;
        drain();
        @(negedge clk);
        chk(in_ready == 1'b1, "R8 ready after drain", in_ready, 1);
        chk(exp_q.size() == 0, "R8 all pairs delivered", exp_q.size(), 0);
        chk(out_valid == 1'b0, "R8 overflow pairs dropped", out_valid, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule